// File: doc/BRIEF.md
# Four-Chip Bit-Serial Event Deinterleaver

The block takes in a byte stream in which every byte holds two nibbles. The upper nibble belongs to the board controller and is discarded. Each bit of the lower nibble is one serial bit from one of four front-end chips. The block finds the header byte that opens an event and then feeds the four lower-nibble bits into four parallel 16-bit shift assemblers. Each group of 16 data bytes completes one word for every chip. The event has a fixed length: `MEAS_WORDS` measurement words per chip, then a four-word trailer, then two blank marker bytes. With the default of 1920 measurement words this gives 30787 bytes per event.

Measurement words arrive Gray coded and leave in binary. The trailer words leave unchanged. They are also captured per chip into side registers: the sample-cell roll position, a 32-bit trigger timestamp made from its upper and lower halves, and the chip identifier. Completed words leave on a valid/ready stream, one chip's word per beat, each tagged with its chip number and word index. When the output side is slow, the input stalls and no data is lost. A malformed event end raises a sticky error, and the block then hunts for the next header.

Top module: `evt_deinterleaver`

## Requirements
- R1: Outside an event, every byte other than the header value `HDR_BYTE` (default 0xA5) is dropped and produces no output. The header byte opens an event.
- R2: Within an event, data bytes fill each word most-significant bit first. Bit k of the lower nibble goes to chip k. The upper nibble has no effect on any output.
- R3: Every word index yields four output beats. They are chips 0, 1, 2 and 3 in that order, each tagged with the same word index. Word indices run upward from 0 to `MEAS_WORDS`+3.
- R4: A word with index below `MEAS_WORDS` is output as the binary value of the Gray code that was received.
- R5: The four trailer words, at indices `MEAS_WORDS` through `MEAS_WORDS`+3, are output exactly as received.
- R6: After an event, each chip has its own trailer registers. `roll_o` holds trailer word 0. `ts_o` holds {trailer word 1, trailer word 2}. `chip_id_o` holds trailer word 3. Each field is packed at chip k's slice.
- R7: When the two bytes after the trailer both equal 0x00, `event_ok_o` pulses high for exactly one cycle.
- R8: If either end-marker byte is not 0x00, `frame_err_o` goes high and stays high until reset. The block then resynchronises: if that byte equals the header value it opens a new event, otherwise it hunts for the next header. Events after the error decode correctly.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output word and its tags hold steady. The input stalls, with `in_ready_o` low, rather than overwrite pending words. No word is lost or duplicated.
- R10: After reset, `out_valid_o` and `frame_err_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_byte_i | input | 8 | Input byte: controller nibble above, chip bits below |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_word_o | output | 16 | Decoded word |
| out_chip_o | output | 2 | Chip index of the word |
| out_idx_o | output | IDX_W | Word index inside the event |
| roll_o | output | 64 | Per-chip roll position, 16 bits each |
| ts_o | output | 128 | Per-chip trigger timestamp, 32 bits each |
| chip_id_o | output | 64 | Per-chip identifier, 16 bits each |
| event_ok_o | output | 1 | One-cycle pulse on a well-formed event end |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
The hardest state to reach from the ports is the stall case. Here the four assemblers have a complete new word ready while the previous word group is still draining, so the last bit of the next word must be held back at the input. The bench reaches it by holding `out_ready_i` low most of the time during one event, which backs the pipeline up on every word boundary. It then checks that `in_ready_o` dropped and that every tagged word still arrives once, in order. A second hard case is resynchronisation after a corrupted end marker, which the bench forces by sending a bad second marker followed by junk and a fresh event.

// File: rtl/evt_deint_pkg.sv
package evt_deint_pkg;
  localparam int CHIPS  = 4;
  localparam int WORD_W = 16;
  localparam int CHIP_W = $clog2(CHIPS);
  localparam int BCNT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_END1, ST_END2} frm_state_e;

  function automatic logic [WORD_W-1:0] gray_to_bin(input logic [WORD_W-1:0] g);
    logic [WORD_W-1:0] b;
    b[WORD_W-1] = g[WORD_W-1];
    for (int i = WORD_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/evt_deint_framer.sv
module evt_deint_framer
  import evt_deint_pkg::*;
#(
  parameter int         TOTAL_WORDS = 1924,
  parameter int         IDX_W       = 11,
  parameter logic [7:0] HDR_BYTE    = 8'hA5,
  parameter logic [7:0] END_BYTE    = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [7:0]       byte_i,
  output logic             in_data_o,
  output logic             last_bit_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             event_ok_o,
  output logic             frame_err_o
);
  frm_state_e        state_q;
  logic [BCNT_W-1:0] bit_cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ok_q, err_q;

  assign in_data_o   = (state_q == ST_DATA);
  assign last_bit_o  = (bit_cnt_q == BCNT_W'(WORD_W-1));
  assign word_idx_o  = idx_q;
  assign event_ok_o  = ok_q;
  assign frame_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ok_q <= 1'b0;
      if (accept_i) begin
        unique case (state_q)
          ST_HUNT: if (byte_i == HDR_BYTE) begin
            state_q   <= ST_DATA;
            bit_cnt_q <= '0;
            idx_q     <= '0;
          end
          ST_DATA: begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (last_bit_o) begin
              if (idx_q == IDX_W'(TOTAL_WORDS-1)) state_q <= ST_END1;
              else                                idx_q   <= idx_q + 1'b1;
            end
          end
          ST_END1, ST_END2: begin
            if (byte_i == END_BYTE) begin
              state_q <= (state_q == ST_END1) ? ST_END2 : ST_HUNT;
              ok_q    <= (state_q == ST_END2);
            end else begin
              // resync: a header byte here opens the next event at once
              err_q     <= 1'b1;
              state_q   <= (byte_i == HDR_BYTE) ? ST_DATA : ST_HUNT;
              bit_cnt_q <= '0;
              idx_q     <= '0;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_deint_assembler.sv
module evt_deint_assembler
  import evt_deint_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_i,
  input  logic [CHIPS-1:0]              nib_i,
  output logic [CHIPS-1:0][WORD_W-1:0]  word_o
);
  for (genvar k = 0; k < CHIPS; k++) begin : g_lane
    logic [WORD_W-2:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[WORD_W-3:0], nib_i[k]};
    end
    // completed word including the bit arriving this cycle
    assign word_o[k] = {sr_q, nib_i[k]};
  end
endmodule

// File: rtl/evt_deint_outbuf.sv
module evt_deint_outbuf
  import evt_deint_pkg::*;
#(
  parameter int MEAS_WORDS = 1920,
  parameter int IDX_W      = 11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [CHIPS-1:0][WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic                         out_ready_i,
  output logic                         busy_o,
  output logic [WORD_W-1:0]            out_word_o,
  output logic [CHIP_W-1:0]            out_chip_o,
  output logic [IDX_W-1:0]             out_idx_o
);
  logic [CHIPS-1:0][WORD_W-1:0] data_q;
  logic [CHIP_W-1:0]            sel_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         busy_q;
  logic                         is_meas;

  assign is_meas = (32'(idx_i) < MEAS_WORDS);

  for (genvar k = 0; k < CHIPS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_q[k] <= '0;
      else if (load_i) data_q[k] <= is_meas ? gray_to_bin(word_i[k]) : word_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sel_q  <= '0;
      idx_q  <= idx_i;
    end else if (busy_q && out_ready_i) begin
      sel_q <= sel_q + 1'b1;
      if (sel_q == CHIP_W'(CHIPS-1)) busy_q <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign out_word_o = data_q[sel_q];
  assign out_chip_o = sel_q;
  assign out_idx_o  = idx_q;
endmodule

// File: rtl/evt_deinterleaver.sv
module evt_deinterleaver
  import evt_deint_pkg::*;
#(
  parameter int         MEAS_WORDS  = 1920,
  parameter logic [7:0] HDR_BYTE    = 8'hA5,
  localparam int        TOTAL_WORDS = MEAS_WORDS + 4,
  localparam int        IDX_W       = $clog2(TOTAL_WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [7:0]             in_byte_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [WORD_W-1:0]      out_word_o,
  output logic [CHIP_W-1:0]      out_chip_o,
  output logic [IDX_W-1:0]       out_idx_o,
  output logic [CHIPS*16-1:0]    roll_o,
  output logic [CHIPS*32-1:0]    ts_o,
  output logic [CHIPS*16-1:0]    chip_id_o,
  output logic                   event_ok_o,
  output logic                   frame_err_o
);
  logic                         accept, in_data, last_bit, busy, load;
  logic [IDX_W-1:0]             word_idx;
  logic [CHIPS-1:0][WORD_W-1:0] asm_word;

  // stall only the byte that would complete a word while the bank drains
  assign in_ready_o = !(in_data && last_bit && busy);
  assign accept     = in_valid_i && in_ready_o;
  assign load       = accept && in_data && last_bit;

  evt_deint_framer #(
    .TOTAL_WORDS(TOTAL_WORDS), .IDX_W(IDX_W), .HDR_BYTE(HDR_BYTE), .END_BYTE(8'h00)
  ) u_framer (
    .clk_i, .rst_ni, .accept_i(accept), .byte_i(in_byte_i),
    .in_data_o(in_data), .last_bit_o(last_bit), .word_idx_o(word_idx),
    .event_ok_o, .frame_err_o
  );

  evt_deint_assembler u_asm (
    .clk_i, .rst_ni, .shift_i(accept && in_data),
    .nib_i(in_byte_i[CHIPS-1:0]), .word_o(asm_word)
  );

  evt_deint_outbuf #(.MEAS_WORDS(MEAS_WORDS), .IDX_W(IDX_W)) u_obuf (
    .clk_i, .rst_ni, .load_i(load), .word_i(asm_word), .idx_i(word_idx),
    .out_ready_i, .busy_o(busy), .out_word_o, .out_chip_o, .out_idx_o
  );

  assign out_valid_o = busy;

  for (genvar k = 0; k < CHIPS; k++) begin : g_trl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        roll_o[k*16 +: 16]    <= '0;
        ts_o[k*32 +: 32]      <= '0;
        chip_id_o[k*16 +: 16] <= '0;
      end else if (load) begin
        if (word_idx == IDX_W'(MEAS_WORDS))     roll_o[k*16 +: 16]    <= asm_word[k];
        if (word_idx == IDX_W'(MEAS_WORDS + 1)) ts_o[k*32+16 +: 16]   <= asm_word[k];
        if (word_idx == IDX_W'(MEAS_WORDS + 2)) ts_o[k*32 +: 16]      <= asm_word[k];
        if (word_idx == IDX_W'(MEAS_WORDS + 3)) chip_id_o[k*16 +: 16] <= asm_word[k];
      end
    end
  end
endmodule

// File: rtl/evt_deint_checker.sv
module evt_deint_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [15:0] out_word_o,
  input logic [1:0]  out_chip_o,
  input logic        event_ok_o,
  input logic        frame_err_o
);
  a_r9_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_word_o) && $stable(out_chip_o));

  a_r3_chip_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_chip_o != 2'd3
      |=> out_valid_o && out_chip_o == $past(out_chip_o) + 2'd1);

  a_r3_first_chip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_chip_o == 2'd0);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  a_r7_ok_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_ok_o |=> !event_ok_o);

  a_r9_stall_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o);
endmodule

bind evt_deinterleaver evt_deint_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_word_o(out_word_o), .out_chip_o(out_chip_o),
  .event_ok_o(event_ok_o), .frame_err_o(frame_err_o)
);

// File: tb/evt_deinterleaver_tb.sv
module evt_deinterleaver_tb_top;
  localparam int MEAS  = 8;
  localparam int TOTAL = MEAS + 4;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [7:0] HDR = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic [15:0] out_word;
  logic [1:0] out_chip;
  logic [IDX_W-1:0] out_idx;
  logic [63:0] roll, chip_id;
  logic [127:0] ts;
  logic ev_ok, ferr;

  always #5 clk = ~clk;

  evt_deinterleaver #(.MEAS_WORDS(MEAS), .HDR_BYTE(HDR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_byte_i(in_byte), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_word_o(out_word), .out_chip_o(out_chip), .out_idx_o(out_idx),
    .roll_o(roll), .ts_o(ts), .chip_id_o(chip_id), .event_ok_o(ev_ok), .frame_err_o(ferr)
  );

  int checks = 0, errors = 0, ok_cnt = 0, stall_cnt = 0, ready_mode = 0;
  bit done = 0;
  logic [15:0] sent [4][TOTAL];
  logic [28:0] exp_q [$];
  logic [15:0] e_roll [4], e_tsh [4], e_tsl [4], e_id [4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // output monitor and ready generator
  always @(negedge clk) begin
    if (rst_n) begin
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = 1'($urandom % 2);
        default: out_ready = ($urandom % 10) == 0;
      endcase
      if (ev_ok) ok_cnt++;
      if (in_valid && !in_ready) stall_cnt++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected word", 64'(out_word), 0);
        else begin
          logic [28:0] e;
          e = exp_q.pop_front();
          chk(out_chip == e[28:27], "R3 chip order", 64'(out_chip), 64'(e[28:27]));
          chk(32'(out_idx) == 32'(e[26:16]), "R3 word index", 64'(out_idx), 64'(e[26:16]));
          chk(out_word == e[15:0], (32'(e[26:16]) < MEAS) ? "R4 R2 gray decode" : "R5 trailer raw",
              64'(out_word), 64'(e[15:0]));
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_byte = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // directed: 0 random, 1 corner patterns
  task automatic build_event(input int directed);
    for (int w = 0; w < TOTAL; w++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] b;
        if (w < MEAS) begin
          if (directed != 0) b = (w % 4 == 0) ? 16'hFFFF : (w % 4 == 1) ? 16'h8000 :
                                 (w % 4 == 2) ? 16'h0001 : 16'(16'h1234 << k);
          else b = 16'($urandom);
          sent[k][w] = b ^ (b >> 1);
        end else begin
          b = (w == MEAS) ? 16'($urandom % 13) : 16'($urandom);
          sent[k][w] = b;
          if (w == MEAS)     e_roll[k] = b;
          if (w == MEAS + 1) e_tsh[k]  = b;
          if (w == MEAS + 2) e_tsl[k]  = b;
          if (w == MEAS + 3) e_id[k]   = b;
        end
        exp_q.push_back({2'(k), 11'(w), b});
      end
    end
  endtask

  task automatic send_event(input logic [7:0] end2);
    send_byte(HDR);
    for (int w = 0; w < TOTAL; w++)
      for (int bi = 15; bi >= 0; bi--)
        send_byte({4'($urandom), sent[3][w][bi], sent[2][w][bi], sent[1][w][bi], sent[0][w][bi]});
    send_byte(8'h00);
    send_byte(end2);
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] j;
      j = 8'($urandom);
      if (j == HDR) j = 8'h5A;
      send_byte(j);
    end
  endtask

  task automatic drain_and_check_trailer(input string tag);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    chk(exp_q.size() == 0, "R9 all words delivered", 64'(exp_q.size()), 0);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(roll[k*16 +: 16] == e_roll[k], "R6 roll", 64'(roll[k*16 +: 16]), 64'(e_roll[k]));
      chk(ts[k*32 +: 32] == {e_tsh[k], e_tsl[k]}, "R6 timestamp", 64'(ts[k*32 +: 32]),
          64'({e_tsh[k], e_tsl[k]}));
      chk(chip_id[k*16 +: 16] == e_id[k], "R6 chip id", 64'(chip_id[k*16 +: 16]), 64'(e_id[k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!out_valid, "R10 out_valid after reset", 64'(out_valid), 0);
    chk(in_ready, "R10 in_ready after reset", 64'(in_ready), 1);
    chk(!ferr, "R10 frame_err after reset", 64'(ferr), 0);

    // R1 junk before any header
    send_junk(20);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 junk ignored", 64'(out_valid), 0);

    // event 1: directed patterns, free-flowing output
    ready_mode = 0;
    build_event(1);
    send_event(8'h00);
    drain_and_check_trailer("e1");
    chk(ok_cnt == 1, "R7 event ok pulse", 64'(ok_cnt), 1);
    chk(!ferr, "R8 no error on clean event", 64'(ferr), 0);

    // event 2: random data, heavy backpressure
    ready_mode = 2;
    stall_cnt = 0;
    build_event(0);
    send_event(8'h00);
    drain_and_check_trailer("e2");
    chk(stall_cnt > 0, "R9 input stalled under backpressure", 64'(stall_cnt), 1);
    chk(ok_cnt == 2, "R7 event ok pulse", 64'(ok_cnt), 2);

    // event 3: corrupt second end marker
    ready_mode = 1;
    build_event(0);
    send_event(8'h01);
    drain_and_check_trailer("e3");
    chk(ferr, "R8 bad marker flags error", 64'(ferr), 1);
    chk(ok_cnt == 2, "R7 no pulse on bad end", 64'(ok_cnt), 2);

    // event 4: resync after junk
    send_junk(7);
    chk(!out_valid, "R1 junk after error ignored", 64'(out_valid), 0);
    build_event(0);
    send_event(8'h00);
    drain_and_check_trailer("e4");
    chk(ok_cnt == 3, "R8 resync decodes next event", 64'(ok_cnt), 3);
    chk(ferr, "R8 error stays sticky", 64'(ferr), 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule